// File: doc/BRIEF.md
# Two-Channel Prescaled Timer with Capture, Compare and Buffered PWM

The block is a general-purpose 16-bit timer with two independent channels. A power-of-two prescaler, fed by a clock-enable strobe for whichever source clock the chip selects, drives a counter. The counter either runs upward and wraps at a programmable modulus, or runs up to the modulus and back down to zero for center-aligned waveforms. Reaching the terminal count raises a flag and an interrupt.

Each channel can be set to one of three jobs. It can latch the count on a chosen edge of its input pin. It can toggle its output pin when the count equals a programmed value. Or it can drive a PWM waveform. PWM duty values are written into a shadow register, and this shadow is copied into the live compare register only at terminal count, so a period is never cut short or stretched. All state sits behind a small word-wide register bus. The bus has a write strobe and a combinational read path.

Register map (word addresses): 0 control, 1 modulus, 2 count, 3 flags, 4 channel 0 config, 5 channel 0 value, 6 channel 1 config, 7 channel 1 value.

Top module: `dual_chan_timer`

## Requirements
- R1: The count advances once every 2^k cycles in which `src_en` is high, where k is control bits [2:0] (address 0). While `src_en` is low, the count does not move.
- R2: After reset the control, count and flag registers read 0 and every pin and interrupt output is low. While the run bit (control bit 3) is 0, the count holds its value.
- R3: In up mode (control bit 4 = 0), the count climbs to the modulus (address 1) and then returns to 0, setting flag bit 0 (address 3) on the wrap. A modulus of 0 acts as 0xFFFF.
- R4: In center mode (control bit 4 = 1), the count rises to the modulus, falls back to 0 and then rises again. Flag bit 0 is set at the bottom turn.
- R5: In capture mode (config bits [1:0] = 0), the input edge chosen by config bits [3:2] (01 rising, 10 falling, 11 either) copies the count into the channel value register and sets flag bit 1+i. An edge that was not chosen does nothing.
- R6: In compare mode (config bits [1:0] = 1), the channel output toggles and flag bit 1+i is set when a new count equals the channel value. A write to the config register drives the output low.
- R7: In edge-aligned PWM (config bits [1:0] = 2, up mode), the output is high while the count is below the active duty. A duty of 0 keeps the output low, and a duty above the modulus keeps it high.
- R8: In PWM mode, a write to the channel value goes into a shadow register that reads back at once. It reaches the output only after the next terminal count.
- R9: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged; a new event in the same cycle wins over a clear. `irq_tc` follows flag bit 0 and `irq_ch[i]` follows flag bit 1+i.
- R10: Any write to the count register (address 2) sets the count to 0.
- R11: In center-aligned PWM with modulus M and duty d ≤ M, the output is high for 2d−1 of every 2M count steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_en | input | 1 | Enable strobe of the selected source clock |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register |
| ch_in | input | 2 | Channel capture inputs |
| ch_out | output | 2 | Channel compare / PWM outputs |
| irq_ch | output | 2 | Per-channel interrupts |
| irq_tc | output | 1 | Terminal-count interrupt |

## Verification
The bench goes after the duty extremes and the shadow load. A duty of 0 or one above the modulus must give a flat line, not a one-cycle sliver, which is what an off-by-one compare produces. A duty write made while the counter is frozen must leave the pin unchanged, which an unbuffered write would not. The center-mode turns are checked sample by sample: a counter that wraps instead of reversing, or that pauses at the top, shows up as a wrong successor of the modulus and a wrong high-time count of 2d−1. Capture is checked for each edge setting against the opposite edge, and flags are checked to survive a write of 0.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int CNT_W  = 16;
  localparam int PS_W   = 3;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    MODE_CAPTURE = 2'd0,
    MODE_COMPARE = 2'd1,
    MODE_PWM     = 2'd2,
    MODE_OFF     = 2'd3
  } ch_mode_e;

  localparam int ADR_CTRL    = 0;
  localparam int ADR_MOD     = 1;
  localparam int ADR_CNT     = 2;
  localparam int ADR_FLAG    = 3;
  localparam int ADR_CH_BASE = 4;
endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            src_en,
  input  logic            run,
  input  logic            clr,
  input  logic [PS_W-1:0] sel,
  output logic            tick
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q, div_n, mask;
  logic             step;

  always_comb begin
    mask = ~({DIV_W{1'b1}} << sel);
    step = run & src_en;
    tick = step & ((div_q & mask) == mask);
    div_n = div_q;
    if (clr)       div_n = '0;
    else if (step) div_n = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_n;
  end
endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic             center,
  input  logic [CNT_W-1:0] modulus,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] top,
  output logic             tc_evt,
  output logic             upd
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             down_q, down_n;
  logic             upd_q;

  always_comb begin
    top    = (modulus == '0) ? '1 : modulus;
    cnt_n  = cnt_q;
    down_n = down_q;
    tc_evt = 1'b0;
    if (clr) begin
      cnt_n  = '0;
      down_n = 1'b0;
    end else if (tick) begin
      if (!center) begin
        down_n = 1'b0;
        if (cnt_q >= top) begin
          cnt_n  = '0;
          tc_evt = 1'b1;
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end else if (!down_q) begin
        if (cnt_q >= top) begin
          down_n = 1'b1;
          cnt_n  = top - CNT_W'(1);
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end else begin
        if (cnt_q == '0) begin
          down_n = 1'b0;
          cnt_n  = CNT_W'(1);
          tc_evt = 1'b1;
        end else begin
          cnt_n = cnt_q - CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      upd_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      down_q <= down_n;
      upd_q  <= tick & ~clr;
    end
  end

  assign cnt = cnt_q;
  assign upd = upd_q;
endmodule

// File: rtl/dct_channel.sv
module dct_channel
  import dct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic             val_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cnt_upd,
  input  logic             tc_evt,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             event_o,
  output logic [3:0]       cfg_rd,
  output logic [CNT_W-1:0] val_rd
);
  ch_mode_e         mode_q, mode_n;
  logic [1:0]       edge_q, edge_n;
  logic [CNT_W-1:0] act_q, act_n, shd_q, shd_n;
  logic [1:0]       sync_q;
  logic             last_q;
  logic             out_q, out_n;
  logic             rise, fall, cap_hit, match;

  always_comb begin
    rise    = sync_q[1] & ~last_q;
    fall    = ~sync_q[1] & last_q;
    cap_hit = (mode_q == MODE_CAPTURE) & ((edge_q[0] & rise) | (edge_q[1] & fall));
    match   = cnt_upd & (cnt == act_q) &
              ((mode_q == MODE_COMPARE) | (mode_q == MODE_PWM));

    mode_n = mode_q;
    edge_n = edge_q;
    if (cfg_wr) begin
      mode_n = ch_mode_e'(wdata[1:0]);
      edge_n = wdata[3:2];
    end

    act_n = act_q;
    shd_n = shd_q;
    case (mode_q)
      MODE_CAPTURE: if (cap_hit) act_n = cnt;
      MODE_COMPARE: if (val_wr)  act_n = wdata;
      MODE_PWM: begin
        if (val_wr) shd_n = wdata;
        if (tc_evt) act_n = shd_q;
      end
      default: ;
    endcase

    if (cfg_wr) begin
      out_n = 1'b0;
    end else begin
      case (mode_q)
        MODE_COMPARE: out_n = out_q ^ match;
        MODE_PWM:     out_n = (cnt < act_q);
        default:      out_n = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      edge_q <= 2'b00;
      act_q  <= '0;
      shd_q  <= '0;
      sync_q <= 2'b00;
      last_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      mode_q <= mode_n;
      edge_q <= edge_n;
      act_q  <= act_n;
      shd_q  <= shd_n;
      sync_q <= {sync_q[0], pin_in};
      last_q <= sync_q[1];
      out_q  <= out_n;
    end
  end

  assign pin_out = out_q;
  assign event_o = cap_hit | match;
  assign cfg_rd  = {edge_q, mode_q};
  assign val_rd  = (mode_q == MODE_PWM) ? shd_q : act_q;
endmodule

// File: rtl/dual_chan_timer.sv
module dual_chan_timer
  import dct_pkg::*;
#(
  parameter int CNT_W  = dct_pkg::CNT_W,
  parameter int PS_W   = dct_pkg::PS_W,
  parameter int NUM_CH = dct_pkg::NUM_CH,
  parameter int ADDR_W = dct_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [NUM_CH-1:0] ch_in,
  output logic [NUM_CH-1:0] ch_out,
  output logic [NUM_CH-1:0] irq_ch,
  output logic              irq_tc
);
  localparam int FLAG_W = NUM_CH + 1;
  localparam int CTRL_W = PS_W + 2;

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [CTRL_W-1:0] ctrl_q, ctrl_n;
  logic [CNT_W-1:0]  modulus_q, modulus_n;
  logic [FLAG_W-1:0] flag_q, flag_n, flag_clr;
  logic [PS_W-1:0]   ps_sel;
  logic              ctl_run, ctl_center;
  logic              wr_ctrl, wr_mod, wr_flag, cnt_clr;
  logic              tick, tc_evt, cnt_upd;
  logic [CNT_W-1:0]  cnt, cnt_top;
  logic [NUM_CH-1:0] ch_ev;
  logic [3:0]        ch_cfg_rd [NUM_CH];
  logic [CNT_W-1:0]  ch_val_rd [NUM_CH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  always_comb begin
    wr_ctrl  = bus_we & (bus_addr == ADDR_W'(ADR_CTRL));
    wr_mod   = bus_we & (bus_addr == ADDR_W'(ADR_MOD));
    cnt_clr  = bus_we & (bus_addr == ADDR_W'(ADR_CNT));
    wr_flag  = bus_we & (bus_addr == ADDR_W'(ADR_FLAG));
    ps_sel     = ctrl_q[PS_W-1:0];
    ctl_run    = ctrl_q[PS_W];
    ctl_center = ctrl_q[PS_W+1];
    ctrl_n    = wr_ctrl ? bus_wdata[CTRL_W-1:0] : ctrl_q;
    modulus_n = wr_mod ? bus_wdata : modulus_q;
    flag_clr  = wr_flag ? bus_wdata[FLAG_W-1:0] : '0;
    flag_n    = (flag_q & ~flag_clr) | {ch_ev, tc_evt};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q    <= '0;
      modulus_q <= '0;
      flag_q    <= '0;
    end else begin
      ctrl_q    <= ctrl_n;
      modulus_q <= modulus_n;
      flag_q    <= flag_n;
    end
  end

  dct_prescaler #(.PS_W(PS_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .src_en (src_en),
    .run    (ctl_run),
    .clr    (cnt_clr),
    .sel    (ps_sel),
    .tick   (tick)
  );

  dct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (tick),
    .clr     (cnt_clr),
    .center  (ctl_center),
    .modulus (modulus_q),
    .cnt     (cnt),
    .top     (cnt_top),
    .tc_evt  (tc_evt),
    .upd     (cnt_upd)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic cfg_wr_i, val_wr_i;
    assign cfg_wr_i = bus_we & (bus_addr == ADDR_W'(ADR_CH_BASE + 2*i));
    assign val_wr_i = bus_we & (bus_addr == ADDR_W'(ADR_CH_BASE + 2*i + 1));

    dct_channel #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .cfg_wr  (cfg_wr_i),
      .val_wr  (val_wr_i),
      .wdata   (bus_wdata),
      .cnt     (cnt),
      .cnt_upd (cnt_upd),
      .tc_evt  (tc_evt),
      .pin_in  (ch_in[i]),
      .pin_out (ch_out[i]),
      .event_o (ch_ev[i]),
      .cfg_rd  (ch_cfg_rd[i]),
      .val_rd  (ch_val_rd[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(ADR_CTRL)) bus_rdata = CNT_W'(ctrl_q);
    if (bus_addr == ADDR_W'(ADR_MOD))  bus_rdata = modulus_q;
    if (bus_addr == ADDR_W'(ADR_CNT))  bus_rdata = cnt;
    if (bus_addr == ADDR_W'(ADR_FLAG)) bus_rdata = CNT_W'(flag_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(ADR_CH_BASE + 2*i))     bus_rdata = CNT_W'(ch_cfg_rd[i]);
      if (bus_addr == ADDR_W'(ADR_CH_BASE + 2*i + 1)) bus_rdata = ch_val_rd[i];
    end
  end

  assign irq_tc = flag_q[0];
  assign irq_ch = flag_q[FLAG_W-1:1];
endmodule

// File: rtl/dual_chan_timer_chk.sv
module dual_chan_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int FLAG_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              src_en,
  input logic              ctl_run,
  input logic              ctl_center,
  input logic              cnt_clr,
  input logic              tick,
  input logic              tc_evt,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cnt_top,
  input logic [FLAG_W-1:0] flag_q
);
  AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (src_en && ctl_run)); // R1

  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_run && !cnt_clr) |=> $stable(cnt)); // R2

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctl_center && cnt == cnt_top) |=> (cnt == '0)); // R3

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctl_center && cnt < cnt_top && !cnt_clr) |=> (cnt == $past(cnt) + CNT_W'(1))); // R3

  AST_CENTER_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ctl_center && cnt == '0 && !cnt_clr) |=> (cnt == CNT_W'(1))); // R4

  AST_TC_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tc_evt |=> flag_q[0]); // R9
endmodule

bind dual_chan_timer dual_chan_timer_chk #(.CNT_W(CNT_W), .FLAG_W(FLAG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .src_en     (src_en),
  .ctl_run    (ctl_run),
  .ctl_center (ctl_center),
  .cnt_clr    (cnt_clr),
  .tick       (tick),
  .tc_evt     (tc_evt),
  .cnt        (cnt),
  .cnt_top    (cnt_top),
  .flag_q     (flag_q)
);

// File: tb/dual_chan_timer_test.sv
module dual_chan_timer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        src_en;
  logic [2:0]  bus_addr;
  logic        bus_we;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [1:0]  ch_in;
  logic [1:0]  ch_out;
  logic [1:0]  irq_ch;
  logic        irq_tc;

  always #2 clk = ~clk;

  dual_chan_timer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_en    (src_en),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ch_in     (ch_in),
    .ch_out    (ch_out),
    .irq_ch    (irq_ch),
    .irq_tc    (irq_tc)
  );

  typedef struct {
    string       tag;
    logic [31:0] val;
  } item_t;

  item_t       exp_q[$];
  logic [31:0] act_q[$];
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  task automatic push_check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    item_t it;
    it.tag = tag;
    it.val = exp;
    exp_q.push_back(it);
    act_q.push_back(act);
  endtask

  always @(negedge clk) begin
    item_t       e;
    logic [31:0] a;
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      e = exp_q.pop_front();
      a = act_q.pop_front();
      checks++;
      if (a !== e.val) begin
        errors++;
        $display("FAIL %s actual=%0h expected=%0h", e.tag, a, e.val);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      h += int'(ch_out[0]);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v2, c;
    int h, mx, mn, bad, prev;
    rst_n = 1'b0; src_en = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; ch_in = 2'b00;
    idle(5);
    rst_n = 1'b1;
    idle(4);

    // R2 reset state
    rd(3'd0, v);  push_check("R2 control after reset", v, 0);
    rd(3'd2, v);  push_check("R2 count after reset", v, 0);
    rd(3'd3, v);  push_check("R2 flags after reset", v, 0);
    push_check("R2 pins after reset", {ch_out, irq_ch, irq_tc}, 0);

    // R1 prescaler
    wr(3'd1, 16'h0000); wr(3'd2, 16'h0000); wr(3'd0, 16'h000B);
    idle(3); rd(3'd2, v); idle(64); rd(3'd2, v2);
    push_check("R1 divide by 8 over 64 cycles", v2 - v, 8);
    wr(3'd0, 16'h0008);
    idle(3); rd(3'd2, v); idle(10); rd(3'd2, v2);
    push_check("R1 divide by 1 over 10 cycles", v2 - v, 10);
    wr(3'd0, 16'h000F);
    idle(3); rd(3'd2, v); idle(256); rd(3'd2, v2);
    push_check("R1 divide by 128 over 256 cycles", v2 - v, 2);
    wr(3'd0, 16'h0008);
    src_en = 1'b0;
    idle(3); rd(3'd2, v); idle(50); rd(3'd2, v2);
    push_check("R1 source enable low pauses", v2 - v, 0);
    src_en = 1'b1;

    // R2 run bit clear holds count
    wr(3'd0, 16'h0000);
    rd(3'd2, v); idle(20); rd(3'd2, v2);
    push_check("R2 stopped count holds", v2 - v, 0);

    // R10 count write clears
    push_check("R10 count nonzero before clear", (v2 != 0), 1);
    wr(3'd2, 16'h1234);
    rd(3'd2, v);
    push_check("R10 count cleared by write", v, 0);

    // R3 up mode wrap at modulus
    wr(3'd1, 16'd9); wr(3'd3, 16'h0007); wr(3'd0, 16'h0008);
    mx = 0;
    repeat (40) begin
      @(negedge clk); rd(3'd2, v);
      if (int'(v) > mx) mx = int'(v);
    end
    push_check("R3 up count peaks at modulus", mx, 9);
    rd(3'd3, v);
    push_check("R3 wrap sets terminal flag", v[0], 1);
    push_check("R9 irq_tc mirrors flag", irq_tc, 1);
    wr(3'd1, 16'h0000); wr(3'd2, 16'h0000);
    idle(300); rd(3'd2, v);
    push_check("R3 modulus 0 runs past small values", (v >= 16'd290), 1);

    // R9 write-one-to-clear
    wr(3'd0, 16'h0000);
    wr(3'd3, 16'h0000); rd(3'd3, v);
    push_check("R9 writing 0 keeps flag", v[0], 1);
    wr(3'd3, 16'h0001); rd(3'd3, v);
    push_check("R9 writing 1 clears flag", v[0], 0);
    push_check("R9 irq_tc low after clear", irq_tc, 0);

    // R6 compare toggles pin
    wr(3'd2, 16'h0000); wr(3'd4, 16'h0001); wr(3'd5, 16'd6); wr(3'd3, 16'h0007);
    push_check("R6 pin low before match", ch_out[0], 0);
    wr(3'd0, 16'h0008);
    idle(12);
    rd(3'd3, v);
    push_check("R6 match sets channel flag", v[1], 1);
    push_check("R6 match toggles pin high", ch_out[0], 1);
    push_check("R9 irq_ch mirrors channel flag", irq_ch[0], 1);
    wr(3'd0, 16'h0000);

    // R7 edge-aligned PWM
    wr(3'd1, 16'd9); wr(3'd4, 16'h0002); wr(3'd5, 16'd4); wr(3'd2, 16'h0000); wr(3'd0, 16'h0008);
    idle(25); count_high(30, h);
    push_check("R7 duty 4 of 10 high cycles", h, 12);
    wr(3'd5, 16'd0); idle(25); count_high(30, h);
    push_check("R7 duty 0 stays low", h, 0);
    wr(3'd5, 16'd12); idle(25); count_high(30, h);
    push_check("R7 duty above modulus stays high", h, 30);

    // R8 buffered duty
    wr(3'd0, 16'h0000); wr(3'd2, 16'h0000); idle(3);
    push_check("R8 pin high before duty write", ch_out[0], 1);
    wr(3'd5, 16'd0); idle(5);
    push_check("R8 duty write has no immediate effect", ch_out[0], 1);
    rd(3'd5, v);
    push_check("R8 shadow reads back", v, 0);
    wr(3'd0, 16'h0008); idle(25); count_high(30, h);
    push_check("R8 new duty applied after terminal count", h, 0);

    // R11 center-aligned PWM
    wr(3'd0, 16'h0000); wr(3'd1, 16'd5); wr(3'd5, 16'd3); wr(3'd2, 16'h0000); wr(3'd0, 16'h0018);
    idle(30); count_high(20, h);
    push_check("R11 center duty 3 of 5 high steps", h, 10);

    // R4 center count shape
    mx = 0; mn = 99; bad = 0; prev = -1;
    repeat (40) begin
      @(negedge clk); rd(3'd2, v);
      if (int'(v) > mx) mx = int'(v);
      if (int'(v) < mn) mn = int'(v);
      if (prev == 5 && v != 16'd4) bad++;
      if (prev == 0 && v != 16'd1) bad++;
      prev = int'(v);
    end
    push_check("R4 center peak", mx, 5);
    push_check("R4 center floor", mn, 0);
    push_check("R4 center reverses at both ends", bad, 0);
    wr(3'd3, 16'h0007); idle(15); rd(3'd3, v);
    push_check("R4 bottom turn sets terminal flag", v[0], 1);

    // R5 input capture
    wr(3'd0, 16'h0000); rd(3'd2, c);
    wr(3'd6, 16'h0004); wr(3'd3, 16'h0007);
    ch_in[1] = 1'b1; idle(6); rd(3'd3, v);
    push_check("R5 rising edge captured", v[2], 1);
    push_check("R9 irq_ch[1] mirrors flag", irq_ch[1], 1);
    rd(3'd7, v);
    push_check("R5 captured value equals count", v, c);
    wr(3'd3, 16'h0004); ch_in[1] = 1'b0; idle(6); rd(3'd3, v);
    push_check("R5 rising mode ignores falling edge", v[2], 0);
    wr(3'd6, 16'h0008); wr(3'd3, 16'h0004);
    ch_in[1] = 1'b1; idle(6); rd(3'd3, v);
    push_check("R5 falling mode ignores rising edge", v[2], 0);
    ch_in[1] = 1'b0; idle(6); rd(3'd3, v);
    push_check("R5 falling edge captured", v[2], 1);
    wr(3'd6, 16'h000C); wr(3'd3, 16'h0004);
    ch_in[1] = 1'b1; idle(6); rd(3'd3, v);
    push_check("R5 both mode rising", v[2], 1);
    wr(3'd3, 16'h0004); ch_in[1] = 1'b0; idle(6); rd(3'd3, v);
    push_check("R5 both mode falling", v[2], 1);

    idle(4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule